// File: doc/BRIEF.md
# Packet Interrupt Coalescing Unit

This unit sits beside a scatter-gather DMA channel and thins out its completion interrupts. Each finished packet is reported by a one-cycle pulse and adds one to a pending count. Instead of interrupting on every packet, the unit raises a single level interrupt once the pending count reaches a programmable threshold. It also raises the interrupt when a programmable number of millisecond ticks has passed since the most recent completion and the count is still nonzero. Software clears the interrupt by acknowledging it. The acknowledge also clears the pending count and the wait timer.

A separate end-of-descriptor-list pulse can raise the interrupt at once, bypassing both the threshold and the timer. This path has its own enable. The threshold, the wait bound and that enable are held in small configuration registers. A single write strobe loads all three. The pending count is visible as an output so that the handler knows how many descriptors to reap.

Top module: `irq_coalesce`

## Requirements
- R1: After reset `irq_o` is 0 and `pending_o` is 0. The stored configuration after reset is threshold 1, wait bound 0 and end-of-list interrupt disabled.
- R2: Each cycle with `pkt_done_i` high and no acknowledge raises `pending_o` by one, visible after that clock edge.
- R3: `pending_o` saturates at 1023 (all ones for the default 10-bit width) and does not wrap.
- R4: When `pending_o` is at or above the stored threshold, `irq_o` is high from the following clock edge. A threshold of 1 therefore interrupts on every packet.
- R5: Writing a threshold of 0 through `cfg_wr_i` stores 1. Any other value from 1 to 1023 is stored as given. The wait bound accepts 0 to 1023.
- R6: With a wait bound W of 1 or more, the timer counts `ms_tick_i` cycles while `pending_o` is nonzero. Once it has counted W ticks, `irq_o` rises one clock edge after the W-th tick.
- R7: A wait bound of 0 disables the timer: ticks never raise `irq_o`.
- R8: Every packet completion restarts the timer from zero.
- R9: With the end-of-list enable set, an `eol_i` pulse raises `irq_o` at the next clock edge, whatever the pending count. With the enable clear, `eol_i` has no effect.
- R10: `irq_ack_i` clears `irq_o`, `pending_o` and the timer at the next edge. A packet completing in the same cycle leaves `pending_o` at 1.
- R11: Once high, `irq_o` stays high until an acknowledge.
- R12: An enabled `eol_i` in the same cycle as `irq_ack_i` leaves `irq_o` high after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pkt_done_i | input | 1 | One-cycle pulse per completed packet |
| ms_tick_i | input | 1 | One-cycle pulse per millisecond |
| eol_i | input | 1 | One-cycle pulse at end of descriptor list |
| irq_ack_i | input | 1 | Interrupt acknowledge pulse |
| cfg_wr_i | input | 1 | Loads the three configuration fields below |
| cfg_thresh_i | input | 10 | Packet threshold to store (0 stored as 1) |
| cfg_wait_i | input | 10 | Wait bound in milliseconds (0 disables the timer) |
| cfg_eol_en_i | input | 1 | End-of-list interrupt enable to store |
| irq_o | output | 1 | Level interrupt |
| pending_o | output | 10 | Packets completed since the last acknowledge |

## Verification
The acknowledge can land in the same cycle as a packet completion or as an end-of-list pulse. The bench drives each pair in one shared cycle. For ack plus packet, it expects `pending_o` of exactly 1 and no interrupt with a threshold above 1. For ack plus enabled end-of-list, it expects the interrupt still high after the edge. Threshold and wait-bound sweeps compute the expected level arithmetically from the packet and tick counts driven.

// File: rtl/irq_coal_pkg.sv
package irq_coal_pkg;
  localparam int unsigned CNT_W_DEF = 10;
  localparam int unsigned TMR_W_DEF = 10;
endpackage

// File: rtl/coal_cfg_regs.sv
module coal_cfg_regs #(
  parameter int unsigned CNT_W = irq_coal_pkg::CNT_W_DEF,
  parameter int unsigned TMR_W = irq_coal_pkg::TMR_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] thr_i,
  input  logic [TMR_W-1:0] wb_i,
  input  logic             en_i,
  output logic [CNT_W-1:0] thr_o,
  output logic [TMR_W-1:0] wb_o,
  output logic             en_o
);
  localparam logic [CNT_W-1:0] THR_ONE = CNT_W'(1);

  logic [CNT_W-1:0] thr_q, thr_d;
  logic [TMR_W-1:0] wb_q, wb_d;
  logic             en_q, en_d;

  always_comb begin
    thr_d = thr_q;
    wb_d  = wb_q;
    en_d  = en_q;
    if (wr_i) begin
      thr_d = (thr_i == '0) ? THR_ONE : thr_i;
      wb_d  = wb_i;
      en_d  = en_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr_q <= THR_ONE;
      wb_q  <= '0;
      en_q  <= 1'b0;
    end else if (wr_i) begin
      thr_q <= thr_d;
      wb_q  <= wb_d;
      en_q  <= en_d;
    end
  end

  assign thr_o = thr_q;
  assign wb_o  = wb_q;
  assign en_o  = en_q;
endmodule

// File: rtl/coal_pkt_counter.sv
module coal_pkt_counter #(
  parameter int unsigned CNT_W = irq_coal_pkg::CNT_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pkt_i,
  input  logic             ack_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = ack_i | (pkt_i & (cnt_q != CNT_MAX));
    if (ack_i) cnt_d = pkt_i ? CNT_W'(1) : '0;
    else       cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/coal_wait_timer.sv
module coal_wait_timer #(
  parameter int unsigned TMR_W = irq_coal_pkg::TMR_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pkt_i,
  input  logic             tick_i,
  input  logic             ack_i,
  input  logic             active_i,
  input  logic [TMR_W-1:0] wb_i,
  output logic             expire_o
);
  logic [TMR_W-1:0] tmr_q, tmr_d;
  logic             tmr_en;
  logic             reached;

  always_comb begin
    reached = (tmr_q >= wb_i);
    tmr_en  = ack_i | pkt_i | (tick_i & active_i & ~reached);
    if (ack_i | pkt_i) tmr_d = '0;
    else               tmr_d = tmr_q + TMR_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tmr_q <= '0;
    else if (tmr_en) tmr_q <= tmr_d;
  end

  assign expire_o = (wb_i != '0) & active_i & reached;
endmodule

// File: rtl/irq_coalesce.sv
module irq_coalesce #(
  parameter int unsigned CNT_W = irq_coal_pkg::CNT_W_DEF,
  parameter int unsigned TMR_W = irq_coal_pkg::TMR_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pkt_done_i,
  input  logic             ms_tick_i,
  input  logic             eol_i,
  input  logic             irq_ack_i,
  input  logic             cfg_wr_i,
  input  logic [CNT_W-1:0] cfg_thresh_i,
  input  logic [TMR_W-1:0] cfg_wait_i,
  input  logic             cfg_eol_en_i,
  output logic             irq_o,
  output logic [CNT_W-1:0] pending_o
);
  logic [CNT_W-1:0] thr_q;
  logic [TMR_W-1:0] wb_q;
  logic             eol_en_q;
  logic [CNT_W-1:0] cnt;
  logic             tmr_expire;
  logic             thr_hit, eol_hit;
  logic             irq_q, irq_d;

  coal_cfg_regs #(.CNT_W(CNT_W), .TMR_W(TMR_W)) u_cfg (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_i  (cfg_wr_i),
    .thr_i (cfg_thresh_i),
    .wb_i  (cfg_wait_i),
    .en_i  (cfg_eol_en_i),
    .thr_o (thr_q),
    .wb_o  (wb_q),
    .en_o  (eol_en_q)
  );

  coal_pkt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .pkt_i (pkt_done_i),
    .ack_i (irq_ack_i),
    .cnt_o (cnt)
  );

  coal_wait_timer #(.TMR_W(TMR_W)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .pkt_i    (pkt_done_i),
    .tick_i   (ms_tick_i),
    .ack_i    (irq_ack_i),
    .active_i (cnt != '0),
    .wb_i     (wb_q),
    .expire_o (tmr_expire)
  );

  always_comb begin
    thr_hit = (cnt >= thr_q);
    eol_hit = eol_i & eol_en_q;
    if (irq_ack_i) irq_d = eol_hit;
    else           irq_d = irq_q | thr_hit | tmr_expire | eol_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign irq_o     = irq_q;
  assign pending_o = cnt;
endmodule

// File: rtl/irq_coalesce_chk.sv
module irq_coalesce_chk #(
  parameter int unsigned CNT_W = irq_coal_pkg::CNT_W_DEF
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pkt_done_i,
  input logic             eol_i,
  input logic             irq_ack_i,
  input logic             irq_o,
  input logic [CNT_W-1:0] pending_o,
  input logic [CNT_W-1:0] thr_q,
  input logic             eol_en_q
);
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

  AST_PEND_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_done_i && !irq_ack_i && pending_o != CMAX) |=> pending_o == $past(pending_o) + CNT_W'(1)); // R2
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (pending_o == CMAX && !irq_ack_i) |=> pending_o == CMAX); // R3
  AST_THRESH_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_ack_i && pending_o >= thr_q) |=> irq_o); // R4
  AST_EOL_IMMEDIATE: assert property (@(posedge clk) disable iff (!rst_n)
    (eol_i && eol_en_q) |=> irq_o); // R9
  AST_ACK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack_i && !(eol_i && eol_en_q)) |=> !irq_o); // R10
  AST_ACK_PKT: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack_i |=> pending_o == (CNT_W'($past(pkt_done_i)))); // R10
  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !irq_ack_i) |=> irq_o); // R11
endmodule

bind irq_coalesce irq_coalesce_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .pkt_done_i (pkt_done_i),
  .eol_i      (eol_i),
  .irq_ack_i  (irq_ack_i),
  .irq_o      (irq_o),
  .pending_o  (pending_o),
  .thr_q      (thr_q),
  .eol_en_q   (eol_en_q)
);

// File: tb/irq_coalesce_test.sv
`timescale 1ns/1ps
module irq_coalesce_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pkt = 1'b0, tick = 1'b0, eol = 1'b0, ack = 1'b0, wr = 1'b0, een = 1'b0;
  logic [9:0] thr = '0, wb = '0;
  logic irq;
  logic [9:0] pend;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  irq_coalesce uut (
    .clk(clk), .rst_n(rst_n), .pkt_done_i(pkt), .ms_tick_i(tick), .eol_i(eol),
    .irq_ack_i(ack), .cfg_wr_i(wr), .cfg_thresh_i(thr), .cfg_wait_i(wb),
    .cfg_eol_en_i(een), .irq_o(irq), .pending_o(pend)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input bit p, input bit t, input bit e, input bit a);
    @(negedge clk);
    pkt = p; tick = t; eol = e; ack = a;
    @(negedge clk);
    pkt = 0; tick = 0; eol = 0; ack = 0;
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic cfg(input int t, input int w, input bit e);
    @(negedge clk);
    wr = 1; thr = 10'(t); wb = 10'(w); een = e;
    @(negedge clk);
    wr = 0;
  endtask

  task automatic clr();
    step(0, 0, 0, 1);
    idle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(); idle();
    chk("R1 irq", irq, 0);
    chk("R1 pending", pend, 0);
    // R1 default threshold 1: one packet interrupts
    step(1, 0, 0, 0); idle();
    chk("R1 default thr irq", irq, 1);
    // R1 default wait 0 and eol disabled
    clr();
    step(0, 0, 1, 0); idle();
    chk("R1 eol disabled", irq, 0);

    // R2 R4 threshold sweep
    for (int t = 1; t <= 6; t++) begin
      cfg(t, 0, 0); clr();
      for (int k = 1; k <= 8; k++) begin
        step(1, 0, 0, 0); idle();
        chk("R2 pending", pend, k);
        chk("R4 irq vs threshold", irq, (k >= t) ? 1 : 0);
      end
    end

    // R11 level held until ack, with ticks and idles
    cfg(2, 0, 0); clr();
    step(1, 0, 0, 0); step(1, 0, 0, 0);
    for (int i = 0; i < 5; i++) step(0, 1, 0, 0);
    chk("R11 irq held", irq, 1);

    // R3 saturation
    cfg(1023, 0, 0); clr();
    for (int k = 0; k < 1030; k++) step(1, 0, 0, 0);
    idle();
    chk("R3 saturated", pend, 1023);
    chk("R4 irq at 1023", irq, 1);

    // R5 threshold 0 stored as 1
    cfg(0, 0, 0); clr();
    step(1, 0, 0, 0); idle();
    chk("R5 thr zero irq", irq, 1);

    // R6 wait bound sweep
    for (int w = 1; w <= 4; w++) begin
      cfg(100, w, 0); clr();
      step(1, 0, 0, 0); idle();
      for (int n = 1; n <= 6; n++) begin
        step(0, 1, 0, 0); idle();
        chk("R6 timer irq", irq, (n >= w) ? 1 : 0);
      end
    end

    // R6 no pending: ticks do nothing
    cfg(100, 1, 0); clr();
    for (int n = 0; n < 4; n++) step(0, 1, 0, 0);
    idle();
    chk("R6 idle timer", irq, 0);

    // R7 wait 0 disables
    cfg(100, 0, 0); clr();
    step(1, 0, 0, 0);
    for (int n = 0; n < 10; n++) step(0, 1, 0, 0);
    idle();
    chk("R7 wait zero", irq, 0);

    // R8 restart on packet
    cfg(100, 3, 0); clr();
    step(1, 0, 0, 0); step(0, 1, 0, 0); step(0, 1, 0, 0);
    step(1, 0, 0, 0); step(0, 1, 0, 0); step(0, 1, 0, 0); idle();
    chk("R8 restarted", irq, 0);
    step(0, 1, 0, 0); idle();
    chk("R8 expire", irq, 1);

    // R9 eol enabled with zero pending
    cfg(100, 0, 1); clr();
    step(0, 0, 1, 0);
    chk("R9 eol immediate", irq, 1);
    chk("R9 pending untouched", pend, 0);

    // R10 ack with packet
    cfg(5, 0, 0); clr();
    step(1, 0, 0, 0); step(1, 0, 0, 0);
    step(1, 0, 0, 1); idle();
    chk("R10 ack pkt pending", pend, 1);
    chk("R10 ack irq", irq, 0);

    // R10 ack clears timer
    cfg(100, 2, 0); clr();
    step(1, 0, 0, 0); step(0, 1, 0, 0);
    step(0, 0, 0, 1); idle();
    chk("R10 ack pending", pend, 0);
    step(1, 0, 0, 0); step(0, 1, 0, 0); idle();
    chk("R10 timer cleared", irq, 0);
    step(0, 1, 0, 0); idle();
    chk("R10 timer rerun", irq, 1);

    // R12 ack and enabled eol together
    cfg(1, 0, 1); clr();
    step(1, 0, 0, 0); idle();
    step(0, 0, 1, 1);
    chk("R12 eol with ack", irq, 1);
    chk("R12 pending cleared", pend, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule